// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block keeps the two memory address windows of a bridge between a primary and a secondary bus and uses them to route memory transactions. One window covers only the low 4 Gbytes. The other covers the full 64-bit space. Both windows have 1-Mbyte granularity.

Software programs the window bounds through a small configuration port. The port has a dword index, byte enables and separate write and read data buses. Reads are combinational.

Each of the decode ports takes a 64-bit address and a direction flag, and returns a hit in the same cycle. A downstream hit means the transaction is claimed for the secondary side. An upstream hit means the address falls outside both windows and is passed toward the primary side.

Top module: `mwin_decode`

## Requirements
- R1: After reset every writable bit is zero. Dword index 8 (byte offset 20h) reads 32'h0000_0000, index 9 (24h) reads 32'h0001_0001, and indices 10 (28h) and 11 (2Ch) read zero.
- R2: Index 8 holds the low-window base in bits [15:0] and its limit in bits [31:16]. Index 9 holds the 64-bit window's lower base in [15:0] and lower limit in [31:16]. Index 10 is that window's upper base dword and index 11 its upper limit dword. A write updates only the bytes whose enable is set. Any other index reads zero and ignores writes.
- R3: Bits [3:0] of each 16-bit bound are read-only. They read 0000b in index 8 and 0001b in index 9.
- R4: The low window matches an address A when A[63:32] is zero and {base[15:4],20'h0} <= A[31:0] <= {limit[15:4],20'hFFFFF}, with both ends inclusive.
- R5: The 64-bit window matches A when {upper base, base[15:4], 20'h0} <= A <= {upper limit, limit[15:4], 20'hFFFFF}, with both ends inclusive. The window can straddle the 4-Gbyte line.
- R6: A window whose full base is greater than its full limit matches no address.
- R7: With the direction flag at 0 (downstream), the hit output is 1 exactly when the address matches either window.
- R8: With the direction flag at 1 (upstream), the hit output is 1 exactly when the address matches neither window.
- R9: Each decode port is combinational and independent of the others. A configuration write changes the decode only after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | AW (6) | Configuration dword index |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_idx, combinational |
| dec_addr | input | NPORT*64 (128) | Decode addresses, port p in bits [64p+63:64p] |
| dec_up | input | NPORT (2) | Direction per port: 1 upstream, 0 downstream |
| dec_hit | output | NPORT (2) | Forward/claim result per port |

## Verification
A configuration write and a decode can occur in the same cycle.

The bench provokes this by raising a write that moves a window while both decode ports present addresses whose result depends on that write. One port is set downstream and the other upstream.

Before the clock edge both results must still follow the old bounds. Just after the edge both must follow the new ones. The bench judges this against its own model of the registers.

// File: rtl/mwin_decode.sv
module mwin_decode #(
  parameter int AW    = 6,
  parameter int NPORT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [AW-1:0]      cfg_idx,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NPORT*64-1:0] dec_addr,
  input  logic [NPORT-1:0]   dec_up,
  output logic [NPORT-1:0]   dec_hit
);

  localparam logic [AW-1:0] I_LOW  = AW'(8);
  localparam logic [AW-1:0] I_PLO  = AW'(9);
  localparam logic [AW-1:0] I_PBHI = AW'(10);
  localparam logic [AW-1:0] I_PLHI = AW'(11);

  logic [11:0] lw_base, lw_lim, pw_base, pw_lim;
  logic [31:0] pw_base_hi, pw_lim_hi;

  wire wr_low = cfg_wr && cfg_idx == I_LOW;
  wire wr_plo = cfg_wr && cfg_idx == I_PLO;
  wire wr_pbh = cfg_wr && cfg_idx == I_PBHI;
  wire wr_plh = cfg_wr && cfg_idx == I_PLHI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lw_base    <= '0;
      lw_lim     <= '0;
      pw_base    <= '0;
      pw_lim     <= '0;
      pw_base_hi <= '0;
      pw_lim_hi  <= '0;
    end else begin
      if (wr_low && cfg_be[0]) lw_base[3:0]  <= cfg_wdata[7:4];
      if (wr_low && cfg_be[1]) lw_base[11:4] <= cfg_wdata[15:8];
      if (wr_low && cfg_be[2]) lw_lim[3:0]   <= cfg_wdata[23:20];
      if (wr_low && cfg_be[3]) lw_lim[11:4]  <= cfg_wdata[31:24];
      if (wr_plo && cfg_be[0]) pw_base[3:0]  <= cfg_wdata[7:4];
      if (wr_plo && cfg_be[1]) pw_base[11:4] <= cfg_wdata[15:8];
      if (wr_plo && cfg_be[2]) pw_lim[3:0]   <= cfg_wdata[23:20];
      if (wr_plo && cfg_be[3]) pw_lim[11:4]  <= cfg_wdata[31:24];
      for (int b = 0; b < 4; b++) begin
        if (wr_pbh && cfg_be[b]) pw_base_hi[8*b +: 8] <= cfg_wdata[8*b +: 8];
        if (wr_plh && cfg_be[b]) pw_lim_hi[8*b +: 8]  <= cfg_wdata[8*b +: 8];
      end
    end
  end

  always_comb begin
    case (cfg_idx)
      I_LOW:   cfg_rdata = {lw_lim, 4'h0, lw_base, 4'h0};
      I_PLO:   cfg_rdata = {pw_lim, 4'h1, pw_base, 4'h1};
      I_PBHI:  cfg_rdata = pw_base_hi;
      I_PLHI:  cfg_rdata = pw_lim_hi;
      default: cfg_rdata = '0;
    endcase
  end

  wire [43:0] pw_lo_bound = {pw_base_hi, pw_base};
  wire [43:0] pw_hi_bound = {pw_lim_hi, pw_lim};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    wire [63:0] a      = dec_addr[64*p +: 64];
    wire        in_low = a[63:32] == 32'h0 && a[31:20] >= lw_base && a[31:20] <= lw_lim;
    wire        in_pw  = a[63:20] >= pw_lo_bound && a[63:20] <= pw_hi_bound;
    assign dec_hit[p] = dec_up[p] ? !(in_low || in_pw) : (in_low || in_pw);

    p_both_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata == 32'h0000_0000 && 1'b0) || !(lw_base > lw_lim && pw_lo_bound > pw_hi_bound)
      || (dec_hit[p] == dec_up[p]));

    p_above4g_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_up[p] && a[63:32] != 32'h0 && pw_lo_bound > pw_hi_bound) |-> !dec_hit[p]);

    p_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (a[63:32] == 32'h0 && a[31:20] == lw_base && lw_base <= lw_lim) |-> dec_hit[p] != dec_up[p]);
  end

  p_ro_nibble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx == I_PLO) |-> (cfg_rdata[3:0] == 4'h1 && cfg_rdata[19:16] == 4'h1));

  p_upper_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pbh && cfg_be == 4'hF) |=> pw_base_hi == $past(cfg_wdata));

endmodule

// File: tb/sim_mwin_decode.sv
module sim_mwin_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [127:0] dec_addr = '0;
  logic [1:0]  dec_up = '0;
  logic [1:0]  dec_hit;

  int checks = 0;
  int fails  = 0;

  logic [11:0] m_lb = '0, m_ll = '0, m_pb = '0, m_pl = '0;
  logic [31:0] m_pbh = '0, m_plh = '0;

  always #2.5 clk = ~clk;

  mwin_decode u0 (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
                  .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
                  .dec_addr(dec_addr), .dec_up(dec_up), .dec_hit(dec_hit));

  function automatic logic ref_hit(logic [63:0] a, logic up);
    logic il, ip;
    il = a[63:32] == 0 && a[31:20] >= m_lb && a[31:20] <= m_ll;
    ip = a[63:20] >= {m_pbh, m_pb} && a[63:20] <= {m_plh, m_pl};
    return up ? !(il || ip) : (il || ip);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_wr(logic [5:0] idx, logic [3:0] be, logic [31:0] d);
    if (idx == 8) begin
      if (be[0]) m_lb[3:0] = d[7:4];
      if (be[1]) m_lb[11:4] = d[15:8];
      if (be[2]) m_ll[3:0] = d[23:20];
      if (be[3]) m_ll[11:4] = d[31:24];
    end else if (idx == 9) begin
      if (be[0]) m_pb[3:0] = d[7:4];
      if (be[1]) m_pb[11:4] = d[15:8];
      if (be[2]) m_pl[3:0] = d[23:20];
      if (be[3]) m_pl[11:4] = d[31:24];
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (idx == 10 && be[b]) m_pbh[8*b +: 8] = d[8*b +: 8];
        if (idx == 11 && be[b]) m_plh[8*b +: 8] = d[8*b +: 8];
      end
    end
  endtask

  task automatic wr(logic [5:0] idx, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_wr(idx, be, d);
  endtask

  task automatic rd(string req, logic [5:0] idx, logic [31:0] exp);
    @(negedge clk);
    cfg_idx = idx;
    #1 chk(req, {32'h0, cfg_rdata}, {32'h0, exp});
  endtask

  task automatic dec(string req, logic [63:0] a0, logic u0v, logic [63:0] a1, logic u1v);
    @(negedge clk);
    dec_addr = {a1, a0}; dec_up = {u1v, u0v};
    #1;
    chk(req, {63'h0, dec_hit[0]}, {63'h0, ref_hit(a0, u0v)});
    chk(req, {63'h0, dec_hit[1]}, {63'h0, ref_hit(a1, u1v)});
  endtask

  task automatic t_reset;
    rd("R1", 8, 32'h0000_0000);
    rd("R1", 9, 32'h0001_0001);
    rd("R1", 10, 32'h0);
    rd("R1", 11, 32'h0);
  endtask

  task automatic t_regs;
    wr(8, 4'hF, 32'hFFFF_FFFF);
    rd("R3", 8, 32'hFFF0_FFF0);
    wr(9, 4'hF, 32'h0000_0000);
    rd("R3", 9, 32'h0001_0001);
    wr(10, 4'h1, 32'h1234_56AA);
    rd("R2", 10, 32'h0000_00AA);
    wr(10, 4'hC, 32'h5500_0000);
    rd("R2", 10, 32'h5500_00AA);
    wr(8, 4'h3, 32'h0000_1230);
    rd("R2", 8, 32'hFFF0_1230);
    wr(12, 4'hF, 32'hDEAD_BEEF);
    rd("R2", 12, 32'h0);
    wr(10, 4'hF, 32'h0);
  endtask

  task automatic t_low;
    wr(8, 4'hF, 32'h1FF0_1000);
    wr(9, 4'hF, 32'h0000_0010);
    dec("R4", 64'h1000_0000, 0, 64'h1FFF_FFFF, 0);
    dec("R4", 64'h0FFF_FFFF, 0, 64'h2000_0000, 0);
    dec("R8", 64'h1000_0000, 1, 64'h0FFF_FFFF, 1);
    dec("R4", 64'h1_1000_0000, 0, 64'h1_1000_0000, 1);
    chk("R4", {63'h0, dec_hit[0]}, 64'h0);
  endtask

  task automatic t_pref;
    wr(9, 4'hF, 32'h0010_FFF0);
    wr(10, 4'hF, 32'h0);
    wr(11, 4'hF, 32'h1);
    dec("R5", 64'hFFF0_0000, 0, 64'hFFEF_FFFF, 0);
    dec("R5", 64'h1_0000_0000, 0, 64'h1_001F_FFFF, 0);
    dec("R5", 64'h1_0020_0000, 0, 64'h1_0020_0000, 1);
    dec("R7", 64'h1500_0000, 0, 64'h1_0000_0000, 1);
    chk("R5", {63'h0, dec_hit[0]}, 64'h1);
  endtask

  task automatic t_disable;
    wr(8, 4'hF, 32'h0FF0_1000);
    dec("R6", 64'h1000_0000, 0, 64'h1000_0000, 1);
    chk("R6", {62'h0, dec_hit}, 64'h2);
    wr(9, 4'hF, 32'h0FF0_0010);
    wr(10, 4'hF, 32'h2);
    dec("R6", 64'h2_0050_0000, 0, 64'h1_0050_0000, 1);
    dec("R8", 64'h0, 1, 64'h0, 0);
  endtask

  task automatic t_same_cycle;
    logic old0, old1;
    wr(8, 4'hF, 32'h1FF0_1000);
    @(negedge clk);
    dec_addr = {64'h3000_0000, 64'h3000_0000}; dec_up = 2'b10;
    cfg_wr = 1'b1; cfg_idx = 8; cfg_be = 4'hC; cfg_wdata = 32'h3FF0_0000;
    #1;
    old0 = ref_hit(64'h3000_0000, 0);
    old1 = ref_hit(64'h3000_0000, 1);
    chk("R9", {63'h0, dec_hit[0]}, {63'h0, old0});
    chk("R9", {63'h0, dec_hit[1]}, {63'h0, old1});
    @(posedge clk);
    #1;
    cfg_wr = 1'b0;
    model_wr(8, 4'hC, 32'h3FF0_0000);
    chk("R9", {63'h0, dec_hit[0]}, {63'h0, ref_hit(64'h3000_0000, 0)});
    chk("R9", {63'h0, dec_hit[1]}, {63'h0, ref_hit(64'h3000_0000, 1)});
    chk("R9", {62'h0, dec_hit}, 64'h1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_low;
    t_pref;
    t_disable;
    t_same_cycle;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule